// File: doc/BRIEF.md
# Bus-Master DMA Command Control

This block holds the software-visible command and status state for up to two storage-channel DMA engines. Software writes an 8-bit command register for each channel to pick the transfer direction and to start or stop the engine. The block turns a 0-to-1 change of the start bit into a one-cycle launch pulse, but only while the global bus-master enable input is high. It then tracks an active flag until the drive side reports that it is done. When the drive reports done, the block raises a sticky interrupt flag. If software stops the engine early, the block classifies the stop as an abort. Descriptor fetching and data movement are handled by the engine that consumes these outputs.

Each channel is a three-state machine. The states are IDLE (start bit clear), ACTIVE (start bit set, transfer running) and HELD (start bit set, no transfer running). The transitions are:
- IDLE→ACTIVE on a start write while the enable input is high (the launch).
- IDLE→HELD on a start write while the enable input is low (the suppressed launch).
- ACTIVE→HELD on a done pulse (completion).
- ACTIVE→IDLE on a stop write (the abort, or a stop that coincides with completion).
- HELD→IDLE on a stop write (the release).

Once the start bit is set, only software can clear it. A stop throws away the transfer, and a later start begins a new one.

Top module: `bm_dma_ctrl`

## Requirements
- R1: After reset, every command and status register reads 00h, and all launch, abort, active and direction outputs are low.
- R2: The channel 0 registers sit at byte offsets 00h (command) and 02h (status); channel 1 uses 08h and 0Ah. In the command register, bit 3 is direction (1 = write memory) and bit 0 is start. In the status register, bit 0 is active and bit 2 is interrupt. All other bits ignore writes and read 0.
- R3: A command write that moves bit 0 from 0 to 1 while `bm_enable` is high produces a one-cycle `start_pulse`, and `active` rises on the same following edge.
- R4: Writing 1 to bit 0 when it already reads 1 produces no launch.
- R5: A 0-to-1 start write while `bm_enable` is low sets bit 0 but launches nothing. No launch follows until bit 0 is cleared and written 1 again with the enable high.
- R6: A `drv_done` pulse while active clears `active` and sets the interrupt bit. Bit 0 stays 1, because hardware never clears it.
- R7: Writing 1 to status bit 2 clears the interrupt bit, and writing 0 leaves it unchanged. If a completion occurs in the same cycle as the clear, the set wins.
- R8: Clearing bit 0 while active, with the interrupt bit clear and no done pulse in the same cycle, gives a one-cycle `abort_pulse`. It also clears `active` and leaves the interrupt bit clear.
- R9: Clearing bit 0 gives no abort if the interrupt bit is already set, or if `drv_done` arrives in the same cycle. In the second case the interrupt bit is set.
- R10: Writes to bit 3 are ignored while active and accepted otherwise.
- R11: `drv_done` has no effect on a channel that is not active.
- R12: The two channels operate independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bm_enable | input | 1 | Global bus-master enable; gates launches |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data at `reg_addr` (combinational) |
| drv_done | input | NUM_CH | Drive-side completion pulse per channel |
| start_pulse | output | NUM_CH | One-cycle launch pulse per channel |
| dir_write | output | NUM_CH | Direction: 1 = engine writes memory |
| active | output | NUM_CH | Transfer in progress |
| abort_pulse | output | NUM_CH | One-cycle abort indication |

## Verification
The bench drives start writes in four situations: from clear with the enable high, from clear with the enable low, repeated while already set, and after a completion. Only the first of these may launch, so these patterns separate edge detection from level detection and check the enable gate. Stops are issued in three situations: mid-transfer with the interrupt bit clear, mid-transfer with a leftover interrupt bit set, and in the same cycle as a done pulse. Together these separate an abort from a normal completion. The bench also tries direction writes during a transfer, done pulses on an idle channel, and a clear that coincides with a completion, to check which update takes priority.

// File: rtl/bm_dma_pkg.sv
package bm_dma_pkg;

    typedef enum logic [1:0] {
        CH_IDLE   = 2'd0,
        CH_ACTIVE = 2'd1,
        CH_HELD   = 2'd2
    } ch_state_t;

    localparam int REG_W      = 8;
    localparam int CMD_START  = 0;
    localparam int CMD_DIR    = 3;
    localparam int STS_ACTIVE = 0;
    localparam int STS_INTR   = 2;
    localparam int CMD_OFS    = 0;
    localparam int STS_OFS    = 2;

endpackage

// File: rtl/bm_dma_chan.sv
module bm_dma_chan
    import bm_dma_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bm_enable,
    input  logic             cmd_wr,
    input  logic             sts_wr,
    input  logic [REG_W-1:0] wdata,
    input  logic             drv_done,
    output logic [REG_W-1:0] cmd_rd,
    output logic [REG_W-1:0] sts_rd,
    output logic             start_pulse,
    output logic             dir_write,
    output logic             active,
    output logic             abort_pulse
);

    ch_state_t state, state_nx;
    logic      intr;
    logic      stop_wr, go_wr;

    assign stop_wr = cmd_wr && !wdata[CMD_START];
    assign go_wr   = cmd_wr &&  wdata[CMD_START];

    always_ff @(posedge clk) begin
        if (!rst_n) state <= CH_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            CH_IDLE: begin
                if (go_wr) state_nx = bm_enable ? CH_ACTIVE : CH_HELD;
            end
            CH_ACTIVE: begin
                if (drv_done)     state_nx = stop_wr ? CH_IDLE : CH_HELD;
                else if (stop_wr) state_nx = CH_IDLE;
            end
            CH_HELD: begin
                if (stop_wr) state_nx = CH_IDLE;
            end
            default: state_nx = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_pulse <= 1'b0;
            abort_pulse <= 1'b0;
            intr        <= 1'b0;
            dir_write   <= 1'b0;
        end else begin
            start_pulse <= (state == CH_IDLE) && (state_nx == CH_ACTIVE);
            abort_pulse <= (state == CH_ACTIVE) && stop_wr && !drv_done && !intr;
            if ((state == CH_ACTIVE) && drv_done)
                intr <= 1'b1;
            else if (sts_wr && wdata[STS_INTR])
                intr <= 1'b0;
            if (cmd_wr && (state != CH_ACTIVE))
                dir_write <= wdata[CMD_DIR];
        end
    end

    assign active = (state == CH_ACTIVE);

    always_comb begin
        cmd_rd             = '0;
        cmd_rd[CMD_START]  = (state != CH_IDLE);
        cmd_rd[CMD_DIR]    = dir_write;
        sts_rd             = '0;
        sts_rd[STS_ACTIVE] = active;
        sts_rd[STS_INTR]   = intr;
    end

    // R3: a launch pulse lasts one cycle and coincides with active rising
    p_pulse_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> !start_pulse);
    p_pulse_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> active);
    // R5: no launch without the enable in the write cycle
    p_launch_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> $past(bm_enable));
    // R6: hardware never clears the start bit by itself
    p_no_self_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_rd[CMD_START] && !cmd_wr) |=> cmd_rd[CMD_START]);
    // R8: an abort leaves the channel stopped and idle
    p_abort_stops_r8: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse |-> (!active && !cmd_rd[CMD_START] && !sts_rd[STS_INTR]));
    // R10: direction stays steady through a transfer
    p_dir_steady_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active)) |-> $stable(dir_write));

endmodule

// File: rtl/bm_dma_ctrl.sv
module bm_dma_ctrl
    import bm_dma_pkg::*;
#(
    parameter int NUM_CH  = 2,
    parameter int ADDR_W  = 4,
    parameter int CH_SPAN = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bm_enable,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic [NUM_CH-1:0] drv_done,
    output logic [NUM_CH-1:0] start_pulse,
    output logic [NUM_CH-1:0] dir_write,
    output logic [NUM_CH-1:0] active,
    output logic [NUM_CH-1:0] abort_pulse
);

    logic [REG_W-1:0] cmd_rd [NUM_CH];
    logic [REG_W-1:0] sts_rd [NUM_CH];
    logic [NUM_CH-1:0] hit_cmd, hit_sts;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        localparam logic [ADDR_W-1:0] CMD_A = ADDR_W'(i * CH_SPAN + CMD_OFS);
        localparam logic [ADDR_W-1:0] STS_A = ADDR_W'(i * CH_SPAN + STS_OFS);

        assign hit_cmd[i] = (reg_addr == CMD_A);
        assign hit_sts[i] = (reg_addr == STS_A);

        bm_dma_chan u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .bm_enable   (bm_enable),
            .cmd_wr      (reg_wr && hit_cmd[i]),
            .sts_wr      (reg_wr && hit_sts[i]),
            .wdata       (reg_wdata),
            .drv_done    (drv_done[i]),
            .cmd_rd      (cmd_rd[i]),
            .sts_rd      (sts_rd[i]),
            .start_pulse (start_pulse[i]),
            .dir_write   (dir_write[i]),
            .active      (active[i]),
            .abort_pulse (abort_pulse[i])
        );
    end

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (hit_cmd[i]) reg_rdata = cmd_rd[i];
            if (hit_sts[i]) reg_rdata = sts_rd[i];
        end
    end

    // R2: reserved command bits always read zero
    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit_cmd) |-> (reg_rdata[7:4] == 4'h0 && reg_rdata[2:1] == 2'b00));

endmodule

// File: tb/bm_dma_ctrl_test.sv
`timescale 1ns/1ps
module bm_dma_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bm_enable = 1'b0;
    logic       reg_wr = 1'b0;
    logic [3:0] reg_addr = 4'h0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic [1:0] drv_done = 2'b00;
    logic [1:0] start_pulse, dir_write, active, abort_pulse;

    always #2 clk = ~clk;

    bm_dma_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bm_enable(bm_enable),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .drv_done(drv_done),
        .start_pulse(start_pulse), .dir_write(dir_write),
        .active(active), .abort_pulse(abort_pulse)
    );

    // behavioural reference state
    bit m_start[2], m_dir[2], m_act[2], m_intr[2], m_sp[2], m_ap[2];
    int tests = 0, fails = 0;
    string req = "R1";

    task automatic chk(string what, int act_v, int exp_v);
        tests++;
        if (act_v != exp_v) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act_v, exp_v, $time);
        end
    endtask

    function automatic int model_read(logic [3:0] a);
        int c = a[3];
        if (a[2:0] == 3'd0) return (int'(m_dir[c]) << 3) | int'(m_start[c]);
        if (a[2:0] == 3'd2) return (int'(m_intr[c]) << 2) | int'(m_act[c]);
        return 0;
    endfunction

    task automatic model_step();
        for (int c = 0; c < 2; c++) begin
            bit cw = reg_wr && reg_addr[3] == c[0] && reg_addr[2:0] == 3'd0;
            bit sw = reg_wr && reg_addr[3] == c[0] && reg_addr[2:0] == 3'd2;
            bit dn = drv_done[c];
            bit old_intr = m_intr[c];
            m_sp[c] = 0; m_ap[c] = 0;
            if (sw && reg_wdata[2]) m_intr[c] = 0;
            if (m_act[c]) begin
                if (dn) begin
                    m_intr[c] = 1; m_act[c] = 0;
                    if (cw && !reg_wdata[0]) m_start[c] = 0;
                end else if (cw && !reg_wdata[0]) begin
                    m_start[c] = 0; m_act[c] = 0; m_ap[c] = !old_intr;
                end
            end else if (cw) begin
                m_dir[c] = reg_wdata[3];
                if (!m_start[c] && reg_wdata[0]) begin
                    m_start[c] = 1;
                    if (bm_enable) begin m_act[c] = 1; m_sp[c] = 1; end
                end else if (!reg_wdata[0]) m_start[c] = 0;
            end
        end
    endtask

    task automatic compare();
        for (int c = 0; c < 2; c++) begin
            chk($sformatf("ch%0d start_pulse", c), start_pulse[c], m_sp[c]);
            chk($sformatf("ch%0d abort_pulse", c), abort_pulse[c], m_ap[c]);
            chk($sformatf("ch%0d active", c), active[c], m_act[c]);
            chk($sformatf("ch%0d dir_write", c), dir_write[c], m_dir[c]);
        end
        chk($sformatf("rdata@%0h", reg_addr), reg_rdata, model_read(reg_addr));
    endtask

    task automatic tick(bit wr, logic [3:0] a, logic [7:0] d, logic [1:0] dn);
        reg_wr = wr; reg_addr = a; reg_wdata = d; drv_done = dn;
        @(posedge clk);
        if (rst_n) model_step();
        @(negedge clk);
        reg_wr = 0; drv_done = 0;
        compare();
    endtask

    task automatic peek(logic [3:0] a);
        tick(0, a, 8'h00, 2'b00);
    endtask

    task automatic wr(logic [3:0] a, logic [7:0] d);
        tick(1, a, d, 2'b00);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        rst_n = 1;
        req = "R1";
        peek(4'h0); peek(4'h2); peek(4'h8); peek(4'hA);
        // R2: layout, reserved bits, R5 suppressed launch
        req = "R2";
        wr(4'h0, 8'hFF); peek(4'h0); peek(4'h2);
        wr(4'h0, 8'h00); peek(4'h0);
        wr(4'h8, 8'hF6); peek(4'h8);
        wr(4'h8, 8'h08); peek(4'h8);
        wr(4'hA, 8'hFF); peek(4'hA);
        wr(4'h8, 8'h00); peek(4'h8);
        // R3: launch
        req = "R3";
        bm_enable = 1;
        wr(4'h0, 8'h01); peek(4'h2); peek(4'h0);
        // R4: repeated start
        req = "R4";
        wr(4'h0, 8'h01); peek(4'h0);
        // R10: direction write while active ignored
        req = "R10";
        wr(4'h0, 8'h09); peek(4'h0);
        // R6: completion
        req = "R6";
        tick(0, 4'h2, 8'h00, 2'b01); peek(4'h0); peek(4'h2);
        // R11: done while not active
        req = "R11";
        tick(0, 4'h2, 8'h00, 2'b01); tick(0, 4'hA, 8'h00, 2'b10); peek(4'h2);
        // R10: direction accepted when held
        req = "R10";
        wr(4'h0, 8'h09); peek(4'h0);
        // R7: clear of interrupt
        req = "R7";
        wr(4'h2, 8'hFB); peek(4'h2);
        wr(4'h2, 8'h04); peek(4'h2);
        // R8: abort
        req = "R8";
        wr(4'h0, 8'h00); wr(4'h0, 8'h01); peek(4'h0);
        wr(4'h0, 8'h00); peek(4'h2); peek(4'h0);
        // R9: stop with leftover interrupt
        req = "R9";
        wr(4'h0, 8'h01); tick(0, 4'h2, 8'h00, 2'b01);
        wr(4'h0, 8'h00); wr(4'h0, 8'h01); peek(4'h2);
        wr(4'h0, 8'h00); peek(4'h2);
        // R9: stop coinciding with done
        wr(4'h2, 8'h04); wr(4'h0, 8'h01);
        tick(1, 4'h0, 8'h00, 2'b01); peek(4'h2); peek(4'h0);
        // R7: set wins over clear
        req = "R7";
        wr(4'h2, 8'h04); wr(4'h0, 8'h01);
        tick(1, 4'h2, 8'h04, 2'b01); peek(4'h2);
        wr(4'h0, 8'h00);
        // R5: enable low suppresses, rewrite does not launch
        req = "R5";
        bm_enable = 0;
        wr(4'h0, 8'h01); peek(4'h0);
        bm_enable = 1;
        wr(4'h0, 8'h01); peek(4'h2);
        wr(4'h0, 8'h00); wr(4'h0, 8'h01); peek(4'h2);
        // R12: independent channels
        req = "R12";
        wr(4'h8, 8'h09); peek(4'hA);
        tick(0, 4'hA, 8'h00, 2'b10); peek(4'hA); peek(4'h2);
        wr(4'h0, 8'h00); peek(4'hA); peek(4'h8);
        wr(4'hA, 8'h04); peek(4'h2); peek(4'hA);
        repeat (4) peek(4'h0);
        finish_run();
    end

endmodule